// File: doc/BRIEF.md
# Line-Crossing Memory Access Splitter

This block sits between a load/store unit and a single cache port. It takes one memory request at a time: start address, byte count (1 to `DATA_BYTES`), a write flag, lock and swap qualifiers, store data and a failed-reservation indication. It decides whether the bytes run past the end of a cache line. If they stay inside one line, it issues one port access. If they cross, it issues two accesses, one after the other, and each stays within its own line. The results of the two halves are joined into one little-endian word. The requester sees one completion pulse, which carries the original address and the full size.

The block also turns the qualifiers into a port command: load-locked, store-conditional, swap, or a plain read or write. A store-conditional whose reservation has already failed finishes at once and never reaches the port. A refused port access leaves the block parked until a retry pulse arrives. A squash input abandons the request in flight: responses still arriving for it are dropped, and no completion is reported.

The controller is one state machine with five states:
- IDLE accepts a request. It goes to SEND, or to DONE for a failed store-conditional.
- SEND presents a half on the port.
  - On acceptance it stays in SEND for the upper half of a crossing access, or moves to WAIT.
  - On refusal it moves to BLOCKED.
  - When squashed it moves to WAIT.
- BLOCKED waits for a retry, then returns to SEND. When squashed it moves to WAIT.
- WAIT holds until as many responses have returned as accesses were sent. It then goes to DONE, or to IDLE when squashed.
- DONE pulses the completion for one cycle and returns to IDLE.

Top module: `lx_access_splitter`

## Requirements
- R1: An access is split only when its last byte address (start + size - 1), rounded down to a multiple of `LINE_BYTES`, is greater than the start address. That rounded value is the upper half's address. An access ending exactly on the last byte of a line goes out as one access.
- R2: The lower half carries (upper address - start) bytes at the start address, and the upper half carries the rest. Every port access has a size of at least 1 and stays inside one line. An access that is not split goes out once with its full size.
- R3: For writes, the lower half's `port_wdata` holds the low bytes of `req_wdata`. The upper half's holds `req_wdata` shifted down by the lower half's byte count. Bytes above `port_size` are zero.
- R4: `done_rdata` is the lower half's response in the low bytes, followed by the upper half's response at an offset equal to the lower half's byte count. Response bytes above the size of their access are ignored, and bytes above the full size read as zero.
- R5: `done_valid` pulses for exactly one cycle, only after every issued half has returned. `done_addr` and `done_size` then carry the original start address and full size. `req_ready` is high in the following cycle.
- R6: The upper half is issued only after the lower half has been accepted, and it carries the same command as the lower half.
- R7: The `port_cmd` encodings are 0 read, 1 load-locked, 2 write, 3 store-conditional and 4 swap.
  - A read with lock gives 1.
  - A write with swap gives 4, whatever the lock bit.
  - A write with lock and no swap gives 3.
  - Any other write gives 2, and any other read gives 0.
- R8: A write with lock, no swap and `req_sc_fail` high completes with `done_valid` and `done_cond_fail` both high two cycles after the request. No port access is made. `done_cond_fail` is low on every other completion.
- R9: After a refused port access (`port_valid` high, `port_accept` low), `port_valid` is low from the next cycle until a `port_retry` pulse. The same half is then presented again.
- R10: Once `squash` has been high during a request, responses returning for it leave `done_rdata` unchanged and no completion pulse follows. A request squashed while blocked makes no further port access. In both cases `req_ready` returns high.
- R11: During reset `req_ready` is high, and `port_valid` and `done_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present (taken when `req_ready` is high) |
| req_ready | output | 1 | Block idle, able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_lock | input | 1 | Locked qualifier (load-locked / store-conditional) |
| req_swap | input | 1 | Swap qualifier for writes |
| req_sc_fail | input | 1 | Reservation already failed for this store-conditional |
| req_addr | input | ADDR_W | Start byte address |
| req_size | input | SZ_W | Byte count, 1 to DATA_BYTES |
| req_wdata | input | DATA_W | Store data, little-endian |
| squash | input | 1 | Abandon the request in flight |
| port_valid | output | 1 | Port access presented |
| port_accept | input | 1 | Port takes the presented access this cycle |
| port_retry | input | 1 | Port can accept again after a refusal |
| port_cmd | output | 3 | Command encoding per R7 |
| port_addr | output | ADDR_W | Byte address of this half |
| port_size | output | SZ_W | Byte count of this half |
| port_wdata | output | DATA_W | Write data of this half, right-aligned |
| resp_valid | input | 1 | One response, in issue order |
| resp_rdata | input | DATA_W | Response data, right-aligned |
| done_valid | output | 1 | Completion pulse |
| done_addr | output | ADDR_W | Original start address |
| done_size | output | SZ_W | Original full size |
| done_rdata | output | DATA_W | Assembled read data (holds its last value) |
| done_cond_fail | output | 1 | Completion was a failed store-conditional |

## Verification
The checks assume the following about the inputs:
- `req_size` lies between 1 and `DATA_BYTES`.
- Responses come back in issue order, one per accepted access.
- `port_retry` is pulsed only while the block is parked after a refusal.
- Squash is not raised in the same cycle as a response that should be kept.

The directed stimulus keeps inside these limits. A port model in the bench answers each accepted access exactly once, one cycle later, and fills the bytes above the access size with a marker value. Retry and squash are raised only from the scenarios written for them.

// File: rtl/lx_split_pkg.sv
package lx_split_pkg;

    typedef enum logic [2:0] {
        CMD_READ        = 3'd0,
        CMD_LOAD_LOCKED = 3'd1,
        CMD_WRITE       = 3'd2,
        CMD_STORE_COND  = 3'd3,
        CMD_SWAP        = 3'd4
    } mem_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_BLOCKED,
        ST_WAIT,
        ST_DONE
    } split_state_e;

endpackage

// File: rtl/lx_split_calc.sv
module lx_split_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int SZ_W       = 4
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [SZ_W-1:0]   total_size,
    output logic              crosses,
    output logic [ADDR_W-1:0] hi_addr,
    output logic [SZ_W-1:0]   lo_size,
    output logic [SZ_W-1:0]   hi_size
);
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'(LINE_BYTES - 1);

    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        // mask arithmetic only: line size is a power of two
        last_byte = base_addr + ADDR_W'(total_size) - ADDR_W'(1);
        hi_addr   = last_byte & ~LINE_MASK;
        crosses   = hi_addr > base_addr;
        lo_size   = crosses ? SZ_W'(hi_addr - base_addr) : total_size;
        hi_size   = crosses ? SZ_W'(base_addr + ADDR_W'(total_size) - hi_addr) : '0;
    end

endmodule

// File: rtl/lx_cmd_map.sv
module lx_cmd_map
    import lx_split_pkg::*;
(
    input  logic     is_write,
    input  logic     lock,
    input  logic     swap,
    output mem_cmd_e cmd
);
    always_comb begin
        if (is_write) begin
            if (swap)      cmd = CMD_SWAP;
            else if (lock) cmd = CMD_STORE_COND;
            else           cmd = CMD_WRITE;
        end else begin
            cmd = lock ? CMD_LOAD_LOCKED : CMD_READ;
        end
    end

endmodule

// File: rtl/lx_read_merge.sv
module lx_read_merge #(
    parameter int DATA_BYTES = 8,
    parameter int SZ_W       = 4,
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              second,
    input  logic [SZ_W-1:0]   offset,
    input  logic [SZ_W-1:0]   part_size,
    input  logic [DATA_W-1:0] part_data,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] part_mask;
    logic [DATA_W-1:0] placed;

    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_lane
        assign part_mask[8*b +: 8] = (SZ_W'(b) < part_size) ? 8'hFF : 8'h00;
    end

    assign placed = (part_data & part_mask) << {offset, 3'b000};

    // first half overwrites, second half ORs in above it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            merged <= '0;
        end else if (take) begin
            merged <= second ? (merged | placed) : placed;
        end
    end

endmodule

// File: rtl/lx_access_splitter.sv
module lx_access_splitter
    import lx_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int DATA_BYTES = 8,
    localparam int SZ_W      = $clog2(DATA_BYTES) + 1,
    localparam int DATA_W    = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_lock,
    input  logic              req_swap,
    input  logic              req_sc_fail,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              squash,
    output logic              port_valid,
    input  logic              port_accept,
    input  logic              port_retry,
    output logic [2:0]        port_cmd,
    output logic [ADDR_W-1:0] port_addr,
    output logic [SZ_W-1:0]   port_size,
    output logic [DATA_W-1:0] port_wdata,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_rdata,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr,
    output logic [SZ_W-1:0]   done_size,
    output logic [DATA_W-1:0] done_rdata,
    output logic              done_cond_fail
);

    split_state_e state_q, state_d;

    logic [ADDR_W-1:0] addr_q;
    logic [SZ_W-1:0]   size_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q, lock_q, swap_q;
    logic              half_q;
    logic [1:0]        sent_q, ret_q;
    logic              sq_q, cf_q;

    logic              crosses;
    logic [ADDR_W-1:0] hi_addr;
    logic [SZ_W-1:0]   lo_size, hi_size;
    mem_cmd_e          cmd;

    logic take_req, sc_fail_now, busy, rsp_take, rsp_second;

    function automatic logic [DATA_W-1:0] keep_bytes(input logic [SZ_W-1:0] n);
        keep_bytes = '0;
        for (int b = 0; b < DATA_BYTES; b++) begin
            keep_bytes[8*b +: 8] = (b < int'(n)) ? 8'hFF : 8'h00;
        end
    endfunction

    lx_split_calc #(
        .ADDR_W    (ADDR_W),
        .LINE_BYTES(LINE_BYTES),
        .SZ_W      (SZ_W)
    ) u_calc (
        .base_addr (addr_q),
        .total_size(size_q),
        .crosses   (crosses),
        .hi_addr   (hi_addr),
        .lo_size   (lo_size),
        .hi_size   (hi_size)
    );

    lx_cmd_map u_cmd (
        .is_write(write_q),
        .lock    (lock_q),
        .swap    (swap_q),
        .cmd     (cmd)
    );

    assign take_req    = (state_q == ST_IDLE) && req_valid;
    assign sc_fail_now = take_req && req_write && req_lock && !req_swap && req_sc_fail;
    assign busy        = (state_q == ST_SEND) || (state_q == ST_BLOCKED) || (state_q == ST_WAIT);
    assign rsp_take    = busy && resp_valid && !sq_q && !squash;
    assign rsp_second  = ret_q[0];

    lx_read_merge #(
        .DATA_BYTES(DATA_BYTES),
        .SZ_W      (SZ_W)
    ) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (rsp_take),
        .second   (rsp_second),
        .offset   (rsp_second ? lo_size : '0),
        .part_size(rsp_second ? hi_size : lo_size),
        .part_data(resp_rdata),
        .merged   (done_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = sc_fail_now ? ST_DONE : ST_SEND;
            end
            ST_SEND: begin
                if (sq_q)             state_d = ST_WAIT;
                else if (port_accept) state_d = (!half_q && crosses) ? ST_SEND : ST_WAIT;
                else                  state_d = ST_BLOCKED;
            end
            ST_BLOCKED: begin
                if (sq_q)            state_d = ST_WAIT;
                else if (port_retry) state_d = ST_SEND;
            end
            ST_WAIT: begin
                if (ret_q == sent_q) state_d = sq_q ? ST_IDLE : ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // request and progress registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            lock_q  <= 1'b0;
            swap_q  <= 1'b0;
            half_q  <= 1'b0;
            sent_q  <= '0;
            ret_q   <= '0;
            sq_q    <= 1'b0;
            cf_q    <= 1'b0;
        end else if (take_req) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            wdata_q <= req_wdata;
            write_q <= req_write;
            lock_q  <= req_lock;
            swap_q  <= req_swap;
            half_q  <= 1'b0;
            sent_q  <= '0;
            ret_q   <= '0;
            sq_q    <= 1'b0;
            cf_q    <= sc_fail_now;
        end else begin
            if (state_q != ST_IDLE) sq_q <= sq_q | squash;
            if (state_q == ST_SEND && !sq_q && port_accept) begin
                sent_q <= sent_q + 2'd1;
                half_q <= 1'b1;
            end
            if (busy && resp_valid) ret_q <= ret_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        port_valid     = (state_q == ST_SEND) && !sq_q;
        port_cmd       = cmd;
        port_addr      = half_q ? hi_addr : addr_q;
        port_size      = half_q ? hi_size : lo_size;
        port_wdata     = half_q ? ((wdata_q >> {lo_size, 3'b000}) & keep_bytes(hi_size))
                                : (wdata_q & keep_bytes(lo_size));
        done_valid     = (state_q == ST_DONE);
        done_addr      = addr_q;
        done_size      = size_q;
        done_cond_fail = (state_q == ST_DONE) && cf_q;
    end

endmodule

// File: rtl/lx_access_splitter_chk.sv
module lx_access_splitter_chk #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int DATA_BYTES = 8,
    localparam int SZ_W      = $clog2(DATA_BYTES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              port_valid,
    input logic              port_accept,
    input logic [2:0]        port_cmd,
    input logic [ADDR_W-1:0] port_addr,
    input logic [SZ_W-1:0]   port_size,
    input logic              done_valid
);
    localparam logic [ADDR_W-1:0] LMASK = ADDR_W'(LINE_BYTES - 1);

    p_line_contained_r2: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid |-> (port_size != '0) &&
            (((port_addr & LMASK) + ADDR_W'(port_size)) <= ADDR_W'(LINE_BYTES)));

    p_same_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid && $past(port_valid) && $past(port_accept) |-> port_cmd == $past(port_cmd));

    p_refused_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid && !port_accept |=> !port_valid);

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid && req_ready);

endmodule

bind lx_access_splitter lx_access_splitter_chk #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .DATA_BYTES(DATA_BYTES)
) u_chk (.*);

// File: tb/lx_access_splitter_tb.sv
module lx_access_splitter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 4;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst_n;
    logic req_valid, req_ready, req_write, req_lock, req_swap, req_sc_fail;
    logic [AW-1:0] req_addr;
    logic [SW-1:0] req_size;
    logic [DW-1:0] req_wdata;
    logic squash, port_valid, port_accept, port_retry;
    logic [2:0] port_cmd;
    logic [AW-1:0] port_addr;
    logic [SW-1:0] port_size;
    logic [DW-1:0] port_wdata;
    logic resp_valid;
    logic [DW-1:0] resp_rdata;
    logic done_valid;
    logic [AW-1:0] done_addr;
    logic [SW-1:0] done_size;
    logic [DW-1:0] done_rdata;
    logic done_cond_fail;

    lx_access_splitter u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int log_n = 0;
    int done_n = 0;
    logic [AW-1:0] log_addr [16];
    logic [SW-1:0] log_size [16];
    logic [2:0]    log_cmd  [16];
    logic [DW-1:0] log_wdata[16];
    logic [AW-1:0] d_addr;
    logic [SW-1:0] d_size;
    logic [DW-1:0] d_rdata;
    logic          d_cf;
    logic          pend;
    logic [DW-1:0] pend_data;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return (a[7:0] * 8'd3) ^ 8'h5A;
    endfunction

    function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a, input int n);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = mem_byte(a + AW'(i));
        return r;
    endfunction

    // port model and observer: one response per accepted access, one cycle later
    initial begin
        resp_valid = 1'b0;
        resp_rdata = '0;
        pend = 1'b0;
        pend_data = '0;
        forever begin
            @(negedge clk);
            resp_valid = pend;
            resp_rdata = pend_data;
            if (rst_n && done_valid) begin
                done_n++;
                d_addr  = done_addr;
                d_size  = done_size;
                d_rdata = done_rdata;
                d_cf    = done_cond_fail;
            end
            if (rst_n && port_valid && port_accept) begin
                log_addr[log_n % 16]  = port_addr;
                log_size[log_n % 16]  = port_size;
                log_cmd[log_n % 16]   = port_cmd;
                log_wdata[log_n % 16] = port_wdata;
                log_n++;
                pend = 1'b1;
                for (int j = 0; j < 8; j++)
                    pend_data[8*j +: 8] = (j < int'(port_size)) ? mem_byte(port_addr + AW'(j)) : 8'hEE;
            end else begin
                pend = 1'b0;
            end
        end
    end

    task automatic drive_req(input logic w, input logic [AW-1:0] a, input int n,
                             input logic lk, input logic sw, input logic scf,
                             input logic [DW-1:0] wd);
        @(negedge clk); #1;
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = SW'(n);
        req_lock = lk; req_swap = sw; req_sc_fail = scf; req_wdata = wd;
        @(negedge clk); #1;
        req_valid = 1'b0; req_lock = 1'b0; req_swap = 1'b0; req_sc_fail = 1'b0;
    endtask

    task automatic wait_done(input int start, input string tag);
        int k = 0;
        while (done_n == start && k < 40) begin
            @(negedge clk); #1;
            k++;
        end
        chk({tag, " completion seen"}, 64'(done_n - start), 64'd1);
    endtask

    task automatic do_access(input logic w, input logic [AW-1:0] a, input int n,
                             input logic lk, input logic sw, input logic scf,
                             input logic [DW-1:0] wd, input string tag);
        int start = done_n;
        drive_req(w, a, n, lk, sw, scf, wd);
        wait_done(start, tag);
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        chk("R11 req_ready in reset", 64'(req_ready), 64'd1);
        chk("R11 port_valid in reset", 64'(port_valid), 64'd0);
        chk("R11 done_valid in reset", 64'(done_valid), 64'd0);
    endtask

    task automatic t_plain_read();
        int b = log_n;
        do_access(1'b0, 32'h100, 4, 1'b0, 1'b0, 1'b0, '0, "R5 plain");
        chk("R2 single access", 64'(log_n - b), 64'd1);
        chk("R2 full size", 64'(log_size[b % 16]), 64'd4);
        chk("R7 read cmd", 64'(log_cmd[b % 16]), 64'd0);
        chk("R4 plain read data", d_rdata, expect_read(32'h100, 4));
        chk("R5 done addr", 64'(d_addr), 64'h100);
        chk("R8 no cond fail", 64'(d_cf), 64'd0);
    endtask

    task automatic t_split_read();
        int b = log_n;
        do_access(1'b0, 32'h13D, 8, 1'b0, 1'b0, 1'b0, '0, "R5 split read");
        chk("R1 two accesses", 64'(log_n - b), 64'd2);
        chk("R2 low addr", 64'(log_addr[b % 16]), 64'h13D);
        chk("R2 low size", 64'(log_size[b % 16]), 64'd3);
        chk("R1 high addr", 64'(log_addr[(b+1) % 16]), 64'h140);
        chk("R2 high size", 64'(log_size[(b+1) % 16]), 64'd5);
        chk("R6 same cmd", 64'(log_cmd[(b+1) % 16]), 64'(log_cmd[b % 16]));
        chk("R4 merged data", d_rdata, expect_read(32'h13D, 8));
        chk("R5 full addr", 64'(d_addr), 64'h13D);
        chk("R5 full size", 64'(d_size), 64'd8);
    endtask

    task automatic t_exact_fit();
        int b = log_n;
        do_access(1'b0, 32'h138, 8, 1'b0, 1'b0, 1'b0, '0, "R1 fit");
        chk("R1 line end no split", 64'(log_n - b), 64'd1);
        chk("R4 fit data", d_rdata, expect_read(32'h138, 8));
    endtask

    task automatic t_split_write();
        int b = log_n;
        do_access(1'b1, 32'h7F, 2, 1'b0, 1'b0, 1'b0, 64'h1122334455667788, "R3 w2");
        chk("R3 two writes", 64'(log_n - b), 64'd2);
        chk("R3 low byte", log_wdata[b % 16], 64'h88);
        chk("R3 high byte", log_wdata[(b+1) % 16], 64'h77);
        chk("R7 write cmd", 64'(log_cmd[b % 16]), 64'd2);
        b = log_n;
        do_access(1'b1, 32'h3A, 8, 1'b0, 1'b0, 1'b0, 64'h0123456789ABCDEF, "R3 w8");
        chk("R2 low size 6", 64'(log_size[b % 16]), 64'd6);
        chk("R3 low data", log_wdata[b % 16], 64'h456789ABCDEF);
        chk("R3 high data", log_wdata[(b+1) % 16], 64'h0123);
    endtask

    task automatic t_commands();
        int b = log_n;
        do_access(1'b0, 32'h200, 4, 1'b1, 1'b0, 1'b0, '0, "R7 ll");
        chk("R7 load-locked cmd", 64'(log_cmd[b % 16]), 64'd1);
        chk("R4 ll data", d_rdata, expect_read(32'h200, 4));
        b = log_n;
        do_access(1'b1, 32'h208, 4, 1'b1, 1'b0, 1'b0, 64'hCAFE, "R7 sc");
        chk("R7 store-cond cmd", 64'(log_cmd[b % 16]), 64'd3);
        chk("R8 sc ok flag", 64'(d_cf), 64'd0);
        b = log_n;
        do_access(1'b1, 32'h3A, 8, 1'b1, 1'b1, 1'b0, 64'h55, "R7 swap");
        chk("R7 swap cmd low", 64'(log_cmd[b % 16]), 64'd4);
        chk("R6 swap cmd high", 64'(log_cmd[(b+1) % 16]), 64'd4);
    endtask

    task automatic t_sc_fail();
        int b = log_n;
        do_access(1'b1, 32'h240, 4, 1'b1, 1'b0, 1'b1, 64'h99, "R8 scfail");
        chk("R8 no port access", 64'(log_n - b), 64'd0);
        chk("R8 cond fail flag", 64'(d_cf), 64'd1);
    endtask

    task automatic t_refuse();
        int b = log_n;
        int start = done_n;
        port_accept = 1'b0;
        drive_req(1'b0, 32'h180, 8, 1'b0, 1'b0, 1'b0, '0);
        chk("R9 presented", 64'(port_valid), 64'd1);
        @(negedge clk); #1;
        chk("R9 quiet after refusal", 64'(port_valid), 64'd0);
        @(negedge clk); #1;
        chk("R9 still quiet", 64'(port_valid), 64'd0);
        port_accept = 1'b1;
        port_retry = 1'b1;
        @(negedge clk); #1;
        port_retry = 1'b0;
        chk("R9 reissued", 64'(port_valid), 64'd1);
        wait_done(start, "R9 refuse");
        chk("R9 one accepted", 64'(log_n - b), 64'd1);
        chk("R9 addr", 64'(log_addr[b % 16]), 64'h180);
        chk("R4 data after retry", d_rdata, expect_read(32'h180, 8));
        @(negedge clk); #1;
    endtask

    task automatic t_squash_resp();
        int start = done_n;
        logic [DW-1:0] prev = done_rdata;
        int k = 0;
        drive_req(1'b0, 32'h300, 8, 1'b0, 1'b0, 1'b0, '0);
        while (!(port_valid && port_accept) && k < 10) begin
            @(negedge clk); #1;
            k++;
        end
        squash = 1'b1;
        @(negedge clk); #1;
        squash = 1'b0;
        repeat (6) @(negedge clk);
        #1;
        chk("R10 no completion", 64'(done_n - start), 64'd0);
        chk("R10 data unchanged", done_rdata, prev);
        chk("R10 ready again", 64'(req_ready), 64'd1);
    endtask

    task automatic t_squash_blocked();
        int b = log_n;
        int start = done_n;
        port_accept = 1'b0;
        drive_req(1'b0, 32'h340, 4, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk); #1;
        squash = 1'b1;
        @(negedge clk); #1;
        squash = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        port_accept = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R10 no access after squash", 64'(log_n - b), 64'd0);
        chk("R10 no completion blocked", 64'(done_n - start), 64'd0);
        chk("R10 ready after abandon", 64'(req_ready), 64'd1);
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_write = 1'b0; req_lock = 1'b0; req_swap = 1'b0;
        req_sc_fail = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
        squash = 1'b0; port_accept = 1'b1; port_retry = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        t_plain_read();
        t_split_read();
        t_exact_fit();
        t_split_write();
        t_commands();
        t_sc_fail();
        t_refuse();
        t_squash_resp();
        t_squash_blocked();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule